// File: doc/BRIEF.md
# Internal Data Memory Unit

This block is the 8-bit internal data space of a small microcontroller core. It holds 256 bytes of RAM and a few special function registers (SFRs) that share the upper half of the address range with that RAM. Four access paths run at the same time. The direct port reaches RAM below 0x80 and the SFRs at or above it. The indirect port reaches every RAM byte. The register port addresses R0–R7 of the bank that the status word selects. The stack port pushes to and pops from RAM through the stack pointer.

All reads are combinational from the stored state. All writes land on the rising clock edge. A synchronous reset puts the SFRs back to their defaults and leaves the RAM contents as they were. The accumulator, B, data pointer, stack pointer and status word are also driven out as ports, so the surrounding datapath can use them.

Top module: `idata_mem`

## Requirements
- R1: The indirect port reads `ram[ind_addr]` combinationally for all 256 addresses. When `ind_we` is high, it writes `ind_wdata` to that byte at the clock edge.
- R2: For a direct address below 0x80, reads and writes go to the same RAM byte that the indirect port sees.
- R3: For a direct address of 0x80 or above, the access goes to the SFRs. It never reads or changes the RAM byte that has the same address.
- R4: The SFR addresses are: accumulator at 0xE0, B at 0xF0, data pointer low byte at 0x82, data pointer high byte at 0x83, stack pointer at 0x81, status word at 0xD0. Each register is readable and writable at its address and is also visible on its own output port.
- R5: Register access with index n works on RAM byte bank*8+n. The bank is status word bits 4:3.
- R6: If the direct port writes the status word in a cycle, a register write in that same cycle uses the bank from before that status write.
- R7: A direct read of an SFR address not listed in R4 returns 0x00. A direct write to such an address changes no state.
- R8: A push first increments SP, with wraparound from 0xFF to 0x00, and then writes `stk_wdata` to RAM at the new SP. `stk_rdata` is always `ram[SP]`. A pop decrements SP. A push in the same cycle as a pop cancels the pop. A push or pop takes precedence over a direct write to SP in the same cycle.
- R9: While `rst` is high at a clock edge, the accumulator, B, data pointer and status word clear to 0x00 and SP loads 0x07.
- R10: When several writes hit the same RAM byte in one cycle, the winner is chosen in this order: push first, then the register port, then the indirect port, then the direct port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir_addr | input | 8 | Direct address |
| dir_we | input | 1 | Direct write enable |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data |
| ind_addr | input | 8 | Indirect (pointer) address |
| ind_we | input | 1 | Indirect write enable |
| ind_wdata | input | 8 | Indirect write data |
| ind_rdata | output | 8 | Indirect read data |
| rn_sel | input | 3 | Register index n within the active bank |
| rn_we | input | 1 | Register write enable |
| rn_wdata | input | 8 | Register write data |
| rn_rdata | output | 8 | Register read data |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| stk_wdata | input | 8 | Data to push |
| stk_rdata | output | 8 | Byte at the top of the stack |
| acc_q | output | 8 | Accumulator |
| b_q | output | 8 | B register |
| dptr_q | output | 16 | Data pointer |
| sp_q | output | 8 | Stack pointer |
| psw_q | output | 8 | Status word |

## Verification
Some rules hold on every cycle, and the assertions check these:
- the stack pointer step after a push or a pop;
- a pushed byte showing up at the top of the stack;
- accumulator writes taking effect;
- SFRs holding steady when no access targets them;
- zero returned on unimplemented SFR reads;
- the reset defaults.

Other behaviour depends on what was written many cycles earlier, so only the bench scenarios can show it:
- the split of the upper half between SFRs and RAM across all addresses;
- register aliasing for each of the four banks;
- the old-bank rule when the status word and a register are written in the same cycle;
- the write priority when several ports hit one byte.

// File: rtl/idata_mem.sv
module idata_mem #(
  parameter logic [7:0] SP_RESET = 8'h07
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  dir_addr,
  input  logic        dir_we,
  input  logic [7:0]  dir_wdata,
  output logic [7:0]  dir_rdata,
  input  logic [7:0]  ind_addr,
  input  logic        ind_we,
  input  logic [7:0]  ind_wdata,
  output logic [7:0]  ind_rdata,
  input  logic [2:0]  rn_sel,
  input  logic        rn_we,
  input  logic [7:0]  rn_wdata,
  output logic [7:0]  rn_rdata,
  input  logic        push,
  input  logic        pop,
  input  logic [7:0]  stk_wdata,
  output logic [7:0]  stk_rdata,
  output logic [7:0]  acc_q,
  output logic [7:0]  b_q,
  output logic [15:0] dptr_q,
  output logic [7:0]  sp_q,
  output logic [7:0]  psw_q
);
  localparam logic [7:0] A_SP  = 8'h81;
  localparam logic [7:0] A_DPL = 8'h82;
  localparam logic [7:0] A_DPH = 8'h83;
  localparam logic [7:0] A_PSW = 8'hD0;
  localparam logic [7:0] A_ACC = 8'hE0;
  localparam logic [7:0] A_B   = 8'hF0;

  logic [7:0] ram [256];
  logic [7:0] sfr_rdata;
  logic [7:0] rn_addr;
  logic [7:0] sp_inc;

  assign rn_addr   = {3'b000, psw_q[4:3], rn_sel};
  assign sp_inc    = sp_q + 8'd1;
  assign ind_rdata = ram[ind_addr];
  assign rn_rdata  = ram[rn_addr];
  assign stk_rdata = ram[sp_q];
  assign dir_rdata = dir_addr[7] ? sfr_rdata : ram[dir_addr];

  always_comb begin
    case (dir_addr)
      A_SP:    sfr_rdata = sp_q;
      A_DPL:   sfr_rdata = dptr_q[7:0];
      A_DPH:   sfr_rdata = dptr_q[15:8];
      A_PSW:   sfr_rdata = psw_q;
      A_ACC:   sfr_rdata = acc_q;
      A_B:     sfr_rdata = b_q;
      default: sfr_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (dir_we && !dir_addr[7]) ram[dir_addr] <= dir_wdata;
    if (ind_we)                 ram[ind_addr] <= ind_wdata;
    if (rn_we)                  ram[rn_addr]  <= rn_wdata;
    if (push)                   ram[sp_inc]   <= stk_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= 8'h00;
      b_q    <= 8'h00;
      dptr_q <= 16'h0000;
      psw_q  <= 8'h00;
      sp_q   <= SP_RESET;
    end else begin
      if (dir_we) begin
        case (dir_addr)
          A_SP:    sp_q         <= dir_wdata;
          A_DPL:   dptr_q[7:0]  <= dir_wdata;
          A_DPH:   dptr_q[15:8] <= dir_wdata;
          A_PSW:   psw_q        <= dir_wdata;
          A_ACC:   acc_q        <= dir_wdata;
          A_B:     b_q          <= dir_wdata;
          default: ;
        endcase
      end
      if (push)     sp_q <= sp_inc;
      else if (pop) sp_q <= sp_q - 8'd1;
    end
  end
endmodule

module idata_mem_chk #(
  parameter logic [7:0] SP_RESET = 8'h07
) (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  dir_addr,
  input logic        dir_we,
  input logic [7:0]  dir_wdata,
  input logic [7:0]  dir_rdata,
  input logic        push,
  input logic        pop,
  input logic [7:0]  stk_wdata,
  input logic [7:0]  stk_rdata,
  input logic [7:0]  acc_q,
  input logic [7:0]  b_q,
  input logic [15:0] dptr_q,
  input logic [7:0]  sp_q,
  input logic [7:0]  psw_q
);
  logic known_sfr;
  assign known_sfr = dir_addr == 8'h81 || dir_addr == 8'h82 || dir_addr == 8'h83 ||
                     dir_addr == 8'hD0 || dir_addr == 8'hE0 || dir_addr == 8'hF0;

  p_reset_defaults_r9: assert property (@(posedge clk)
    rst |=> (sp_q == SP_RESET && psw_q == 8'h00 && acc_q == 8'h00 && b_q == 8'h00 && dptr_q == 16'h0000));

  p_push_sp_step_r8: assert property (@(posedge clk) disable iff (rst)
    push |=> sp_q == $past(sp_q) + 8'd1);

  p_pop_sp_step_r8: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> sp_q == $past(sp_q) - 8'd1);

  p_push_top_data_r8: assert property (@(posedge clk) disable iff (rst)
    push |=> stk_rdata == $past(stk_wdata));

  p_acc_write_r4: assert property (@(posedge clk) disable iff (rst)
    (dir_we && dir_addr == 8'hE0) |=> acc_q == $past(dir_wdata));

  p_unimpl_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (dir_addr[7] && !known_sfr) |-> dir_rdata == 8'h00);

  p_sfr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop && (!dir_we || (dir_addr[7] && !known_sfr))) |=>
      ($stable(sp_q) && $stable(psw_q) && $stable(acc_q) && $stable(b_q) && $stable(dptr_q)));
endmodule

bind idata_mem idata_mem_chk #(.SP_RESET(SP_RESET)) chk_i (
  .clk(clk), .rst(rst), .dir_addr(dir_addr), .dir_we(dir_we), .dir_wdata(dir_wdata),
  .dir_rdata(dir_rdata), .push(push), .pop(pop), .stk_wdata(stk_wdata),
  .stk_rdata(stk_rdata), .acc_q(acc_q), .b_q(b_q), .dptr_q(dptr_q), .sp_q(sp_q),
  .psw_q(psw_q)
);

// File: tb/idata_mem_tb_top.sv
module idata_mem_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  dir_addr, dir_wdata, ind_addr, ind_wdata, rn_wdata, stk_wdata;
  logic        dir_we, ind_we, rn_we, push, pop;
  logic [2:0]  rn_sel;
  logic [7:0]  dir_rdata, ind_rdata, rn_rdata, stk_rdata, acc_q, b_q, sp_q, psw_q;
  logic [15:0] dptr_q;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_acc, m_b, m_dpl, m_dph, m_sp, m_psw;

  idata_mem dut_i (
    .clk(clk), .rst(rst),
    .dir_addr(dir_addr), .dir_we(dir_we), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
    .ind_addr(ind_addr), .ind_we(ind_we), .ind_wdata(ind_wdata), .ind_rdata(ind_rdata),
    .rn_sel(rn_sel), .rn_we(rn_we), .rn_wdata(rn_wdata), .rn_rdata(rn_rdata),
    .push(push), .pop(pop), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
    .acc_q(acc_q), .b_q(b_q), .dptr_q(dptr_q), .sp_q(sp_q), .psw_q(psw_q)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [7:0] pat1(input int a);
    return 8'(a * 37 + 5);
  endfunction

  function automatic logic [7:0] pat2(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    dir_we = 0; ind_we = 0; rn_we = 0; push = 0; pop = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic do_reset();
    rst = 1; idle();
    tick(); tick();
    rst = 0;
  endtask

  function automatic logic [7:0] sfr_model(input int a);
    case (a)
      8'h81: return m_sp;
      8'h82: return m_dpl;
      8'h83: return m_dph;
      8'hD0: return m_psw;
      8'hE0: return m_acc;
      8'hF0: return m_b;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    dir_addr = 0; dir_wdata = 0; ind_addr = 0; ind_wdata = 0; rn_sel = 0;
    rn_wdata = 0; stk_wdata = 0;
    do_reset();

    check("R9 sp", {8'h0, sp_q}, 16'h0007);
    check("R9 psw", {8'h0, psw_q}, 16'h0000);
    check("R9 acc", {8'h0, acc_q}, 16'h0000);
    check("R9 b", {8'h0, b_q}, 16'h0000);
    check("R9 dptr", dptr_q, 16'h0000);
    dir_addr = 8'h81; #1;
    check("R4 sp direct read", {8'h0, dir_rdata}, 16'h0007);

    // R1: fill and read back every byte through the indirect port
    for (int a = 0; a < 256; a++) begin
      ind_addr = 8'(a); ind_wdata = pat1(a); ind_we = 1; tick();
    end
    for (int a = 0; a < 256; a++) begin
      ind_addr = 8'(a); #1;
      check("R1 indirect readback", {8'h0, ind_rdata}, {8'h0, pat1(a)});
    end

    // R2 / R3: lower half reaches RAM, upper half reaches the SFRs
    m_acc = 0; m_b = 0; m_dpl = 0; m_dph = 0; m_sp = 8'h07; m_psw = 0;
    for (int a = 0; a < 256; a++) begin
      dir_addr = 8'(a); #1;
      if (a < 128) check("R2 direct read of RAM", {8'h0, dir_rdata}, {8'h0, pat1(a)});
      else         check("R3 R7 direct read of SFR", {8'h0, dir_rdata}, {8'h0, sfr_model(a)});
    end
    for (int a = 0; a < 128; a++) begin
      dir_addr = 8'(a); dir_wdata = pat2(a); dir_we = 1; tick();
    end
    for (int a = 0; a < 128; a++) begin
      ind_addr = 8'(a); #1;
      check("R2 direct write seen indirectly", {8'h0, ind_rdata}, {8'h0, pat2(a)});
    end

    // R3 / R4 / R7: write every upper address directly
    for (int a = 128; a < 256; a++) begin
      logic [7:0] v;
      v = 8'(a) ^ 8'h3C;
      dir_addr = 8'(a); dir_wdata = v; dir_we = 1; tick();
      case (a)
        8'h81: m_sp = v;
        8'h82: m_dpl = v;
        8'h83: m_dph = v;
        8'hD0: m_psw = v;
        8'hE0: m_acc = v;
        8'hF0: m_b = v;
        default: ;
      endcase
    end
    for (int a = 128; a < 256; a++) begin
      dir_addr = 8'(a); ind_addr = 8'(a); #1;
      check("R4 R7 SFR after writes", {8'h0, dir_rdata}, {8'h0, sfr_model(a)});
      check("R3 upper RAM untouched", {8'h0, ind_rdata}, {8'h0, pat1(a)});
    end
    check("R4 acc port", {8'h0, acc_q}, {8'h0, m_acc});
    check("R4 b port", {8'h0, b_q}, {8'h0, m_b});
    check("R4 dptr port", dptr_q, {m_dph, m_dpl});
    check("R4 sp port", {8'h0, sp_q}, {8'h0, m_sp});
    check("R4 psw port", {8'h0, psw_q}, {8'h0, m_psw});

    do_reset();
    check("R9 sp after second reset", {8'h0, sp_q}, 16'h0007);
    ind_addr = 8'h05; #1;
    check("R9 RAM kept over reset", {8'h0, ind_rdata}, {8'h0, pat2(5)});

    // R5: each bank aliases bank*8+n
    for (int bk = 0; bk < 4; bk++) begin
      dir_addr = 8'hD0; dir_wdata = 8'(bk << 3); dir_we = 1; tick();
      for (int n = 0; n < 8; n++) begin
        rn_sel = 3'(n); rn_wdata = 8'(bk * 16 + n + 64); rn_we = 1; tick();
      end
      for (int n = 0; n < 8; n++) begin
        rn_sel = 3'(n); ind_addr = 8'(bk * 8 + n); #1;
        check("R5 bank alias in RAM", {8'h0, ind_rdata}, 16'(bk * 16 + n + 64));
        check("R5 register read", {8'h0, rn_rdata}, 16'(bk * 16 + n + 64));
      end
    end

    // R6: status write and register write in one cycle use the old bank (3)
    dir_addr = 8'hD0; dir_wdata = 8'h10; dir_we = 1;
    rn_sel = 3'd5; rn_wdata = 8'hEE; rn_we = 1; tick();
    ind_addr = 8'd29; #1;
    check("R6 write went to old bank", {8'h0, ind_rdata}, 16'h00EE);
    ind_addr = 8'd21; #1;
    check("R6 new bank untouched", {8'h0, ind_rdata}, 16'(2 * 16 + 5 + 64));
    rn_sel = 3'd5; #1;
    check("R6 read uses new bank next cycle", {8'h0, rn_rdata}, 16'(2 * 16 + 5 + 64));

    // R8: stack
    do_reset();
    stk_wdata = 8'h11; push = 1; tick();
    stk_wdata = 8'h22; push = 1; tick();
    stk_wdata = 8'h33; push = 1; tick();
    check("R8 sp after three pushes", {8'h0, sp_q}, 16'h000A);
    ind_addr = 8'h08; #1;
    check("R8 first push at 0x08", {8'h0, ind_rdata}, 16'h0011);
    ind_addr = 8'h0A; #1;
    check("R8 third push at 0x0A", {8'h0, ind_rdata}, 16'h0033);
    check("R8 top before pop", {8'h0, stk_rdata}, 16'h0033);
    pop = 1; tick();
    check("R8 sp after pop", {8'h0, sp_q}, 16'h0009);
    check("R8 top after pop", {8'h0, stk_rdata}, 16'h0022);
    pop = 1; tick();
    stk_wdata = 8'h44; push = 1; pop = 1; tick();
    check("R8 push cancels pop sp", {8'h0, sp_q}, 16'h0009);
    check("R8 push cancels pop data", {8'h0, stk_rdata}, 16'h0044);
    dir_addr = 8'h81; dir_wdata = 8'h50; dir_we = 1; stk_wdata = 8'h55; push = 1; tick();
    check("R8 push beats SP write", {8'h0, sp_q}, 16'h000A);
    check("R8 push beats SP write data", {8'h0, stk_rdata}, 16'h0055);
    dir_addr = 8'h81; dir_wdata = 8'hFF; dir_we = 1; tick();
    stk_wdata = 8'h66; push = 1; tick();
    check("R8 sp wraps to 0x00", {8'h0, sp_q}, 16'h0000);
    ind_addr = 8'h00; #1;
    check("R8 wrapped push at 0x00", {8'h0, ind_rdata}, 16'h0066);
    pop = 1; tick();
    check("R8 pop wraps to 0xFF", {8'h0, sp_q}, 16'h00FF);

    // R10: write priority on a shared byte (bank 0 after reset)
    do_reset();
    dir_addr = 8'h30; dir_wdata = 8'hD1; dir_we = 1;
    ind_addr = 8'h30; ind_wdata = 8'hA1; ind_we = 1; tick();
    ind_addr = 8'h30; #1;
    check("R10 indirect beats direct", {8'h0, ind_rdata}, 16'h00A1);
    ind_addr = 8'h03; ind_wdata = 8'hA2; ind_we = 1;
    rn_sel = 3'd3; rn_wdata = 8'hB2; rn_we = 1; tick();
    ind_addr = 8'h03; #1;
    check("R10 register beats indirect", {8'h0, ind_rdata}, 16'h00B2);
    dir_addr = 8'h81; dir_wdata = 8'h02; dir_we = 1; tick();
    stk_wdata = 8'hC3; push = 1;
    rn_sel = 3'd3; rn_wdata = 8'hB3; rn_we = 1; tick();
    ind_addr = 8'h03; #1;
    check("R10 push beats register", {8'h0, ind_rdata}, 16'h00C3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule